// File: doc/BRIEF.md
# Branch hazard fetch controller

This block is the fetch-side control of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It holds the program counter and the valid latch of the instruction held between fetch and decode. The branch outcome and the branch target are both known while the branch sits in decode, and the decode stage reports them to this block.

A static mode input selects how branches are handled. Freeze mode holds fetch for one cycle whenever a branch is decoded. Predict-not-taken mode keeps fetching sequentially and squashes the wrongly fetched instruction when the branch is taken. Delayed mode gives one delay slot, which always executes unless the branch is a cancelling one whose direction hint proves wrong, in which case the slot is annulled.

Annulment clears a valid tag that travels with the instruction. Stages further down must block register and memory writes for any instruction whose tag is clear. A bubble output marks each cycle in which a branch costs an issue slot, and an error output flags the illegal case of a branch placed in a delay slot.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: A synchronous reset sets fetch_pc to 0 and clears id_valid, id_annul and ex_valid.
- R2: When no valid branch is in decode, fetch_pc advances by 4 on the next cycle and id_valid is 1 on the next cycle.
- R3: With mode 0 (freeze) and a valid branch in decode, stall is 1 in that cycle and id_valid is 0 on the next cycle. The next fetch_pc is id_target if id_taken is 1, and otherwise it stays at its current value, so that address is fetched again.
- R4: With mode 1 or 3 (predict not taken) and a valid taken branch in decode, the next fetch_pc is id_target and id_valid is 0 on the next cycle. A valid untaken branch behaves as in R2.
- R5: With mode 2 (delayed) and a valid branch in decode, id_valid is 1 on the next cycle, because the delay slot always enters decode. The next fetch_pc is id_target if id_taken is 1 and fetch_pc+4 otherwise.
- R6: In mode 2, when a valid branch in decode has id_cancel at 1 and id_taken differs from id_pred_taken, id_annul is 1 in the next cycle. It is 0 in every other case.
- R7: bubble is 1 in exactly three cases: any valid branch in decode in mode 0, a valid taken branch in mode 1 or 3, and the R6 mismatch case in mode 2. It is 0 at all other times.
- R8: slot_error is 1 when, in mode 2, a valid branch is in decode and that instruction is itself the delay slot of the previous branch. It is 0 at all other times.
- R9: While id_valid is 0, the decode inputs have no effect on fetch_pc, id_valid, stall, bubble or slot_error.
- R10: ex_valid on each cycle equals id_valid AND NOT id_annul from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Branch scheme: 0 freeze, 1 or 3 predict not taken, 2 delayed |
| id_branch | input | 1 | The decode instruction is a conditional branch |
| id_taken | input | 1 | Resolved branch outcome |
| id_target | input | AW | Resolved branch target |
| id_cancel | input | 1 | The branch is a cancelling branch |
| id_pred_taken | input | 1 | Direction hint of a cancelling branch |
| fetch_pc | output | AW | Address fetched in this cycle |
| stall | output | 1 | The fetch in this cycle is discarded (freeze mode) |
| id_valid | output | 1 | The instruction in decode is valid |
| id_annul | output | 1 | The instruction in decode is an annulled delay slot |
| ex_valid | output | 1 | Valid tag of the instruction in execute |
| bubble | output | 1 | A branch costs one issue slot in this cycle |
| slot_error | output | 1 | Illegal branch in a delay slot |

## Verification
A behavioural reference model tracks the instruction stream in each of the three modes. A pseudo-random stream of taken, untaken, cancelling and hinted branches drives it. Freeze runs separate refetch from redirect. Predict-not-taken runs separate the free untaken path from the squashed taken path. Delayed runs separate cancelling branches whose hint matched from those whose hint was wrong, and a final phase places branches in delay slots to raise the error flag. Whenever decode is empty, the bench drives taken branches on the decode inputs to show that they are ignored.

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          id_branch,
  input  logic          id_taken,
  input  logic [AW-1:0] id_target,
  input  logic          id_cancel,
  input  logic          id_pred_taken,
  output logic [AW-1:0] fetch_pc,
  output logic          stall,
  output logic          id_valid,
  output logic          id_annul,
  output logic          ex_valid,
  output logic          bubble,
  output logic          slot_error
);
  localparam logic [1:0]    M_FRZ = 2'd0;
  localparam logic [1:0]    M_DLY = 2'd2;
  localparam logic [AW-1:0] INC   = AW'(STEP);

  logic frz, dly, pnt, br, miss, slot_q, next_v;
  logic [AW-1:0] next_pc;

  assign frz  = (mode == M_FRZ);
  assign dly  = (mode == M_DLY);
  assign pnt  = !frz && !dly;
  assign br   = id_valid && id_branch;
  assign miss = id_cancel && (id_taken != id_pred_taken);

  assign stall      = frz && br;
  assign bubble     = br && (frz || (pnt && id_taken) || (dly && miss));
  assign slot_error = dly && br && slot_q;
  assign next_v     = !(br && (frz || (pnt && id_taken)));

  always_comb begin
    if (br && id_taken)  next_pc = id_target;
    else if (br && frz)  next_pc = fetch_pc;
    else                 next_pc = fetch_pc + INC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= '0;
      id_valid <= 1'b0;
      id_annul <= 1'b0;
      ex_valid <= 1'b0;
      slot_q   <= 1'b0;
    end else begin
      fetch_pc <= next_pc;
      id_valid <= next_v;
      slot_q   <= dly && br;
      id_annul <= dly && br && miss;
      ex_valid <= id_valid && !id_annul;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc == '0) && !id_valid && !id_annul && !ex_valid);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    !br |=> id_valid && (fetch_pc == $past(fetch_pc) + INC));

  a_r3_freeze_hole: assert property (@(posedge clk) disable iff (rst)
    (frz && br) |=> !id_valid);

  a_r4_squash_taken: assert property (@(posedge clk) disable iff (rst)
    (pnt && br && id_taken) |=> !id_valid && (fetch_pc == $past(id_target)));

  a_r5_slot_enters: assert property (@(posedge clk) disable iff (rst)
    (dly && br) |=> id_valid);

  a_r6_cancel_kills: assert property (@(posedge clk) disable iff (rst)
    (dly && br && miss) |=> id_valid ##1 !ex_valid);

  a_r8_no_error_outside_delayed: assert property (@(posedge clk) disable iff (rst)
    !dly |-> !slot_error);

  a_r10_invalid_stays_invalid: assert property (@(posedge clk) disable iff (rst)
    !id_valid |=> !ex_valid);
endmodule

// File: tb/branch_fetch_ctrl_test.sv
module branch_fetch_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic id_branch = 0, id_taken = 0, id_cancel = 0, id_pred_taken = 0;
  logic [31:0] id_target = 0;
  logic [31:0] fetch_pc;
  logic stall, id_valid, id_annul, ex_valid, bubble, slot_error;

  branch_fetch_ctrl #(.AW(32), .STEP(4)) uut (
    .clk(clk), .rst(rst), .mode(mode), .id_branch(id_branch), .id_taken(id_taken),
    .id_target(id_target), .id_cancel(id_cancel), .id_pred_taken(id_pred_taken),
    .fetch_pc(fetch_pc), .stall(stall), .id_valid(id_valid), .id_annul(id_annul),
    .ex_valid(ex_valid), .bubble(bubble), .slot_error(slot_error));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] m_pc;
  bit m_idv, m_slot, m_ann, m_exv;
  string pc_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  task automatic do_reset(logic [1:0] md);
    @(negedge clk);
    rst = 1; mode = md;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1 fetch_pc", fetch_pc, 0);
    chk("R1 id_valid", {31'b0, id_valid}, 0);
    chk("R1 id_annul", {31'b0, id_annul}, 0);
    chk("R1 ex_valid", {31'b0, ex_valid}, 0);
    m_pc = 0; m_idv = 0; m_slot = 0; m_ann = 0; m_exv = 0;
    pc_tag = "R1";
  endtask

  task automatic run(int cycles, bit inject);
    for (int c = 0; c < cycles; c++) begin
      bit br, miss, frz, dly, pnt, e_stall, e_bub, e_err, n_idv;
      logic [31:0] n_pc;
      string nxt;
      step_lfsr();
      if (m_idv) begin
        id_branch = (lfsr[2:0] < 3'd3) && (!m_slot || inject);
        id_taken = lfsr[5]; id_cancel = lfsr[7]; id_pred_taken = lfsr[9];
        id_target = {22'b0, lfsr[13:6], 2'b00};
      end else begin
        id_branch = 1; id_taken = 1; id_cancel = 1; id_pred_taken = 0;
        id_target = 32'h0000_4440;
      end
      frz = (mode == 2'd0); dly = (mode == 2'd2); pnt = !frz && !dly;
      br = m_idv && id_branch;
      miss = id_cancel && (id_taken != id_pred_taken);
      e_stall = frz && br;
      e_bub = br && (frz || (pnt && id_taken) || (dly && miss));
      e_err = dly && br && m_slot;
      #1;
      chk({pc_tag, " fetch_pc"}, fetch_pc, m_pc);
      chk({pc_tag, " id_valid"}, {31'b0, id_valid}, {31'b0, m_idv});
      chk("R3 stall", {31'b0, stall}, {31'b0, e_stall});
      chk("R7 bubble", {31'b0, bubble}, {31'b0, e_bub});
      chk("R8 slot_error", {31'b0, slot_error}, {31'b0, e_err});
      chk("R6 id_annul", {31'b0, id_annul}, {31'b0, m_ann});
      chk("R10 ex_valid", {31'b0, ex_valid}, {31'b0, m_exv});
      if (!br) begin
        n_pc = m_pc + 4; n_idv = 1; nxt = m_idv ? "R2" : "R9";
      end else if (frz) begin
        n_pc = id_taken ? id_target : m_pc; n_idv = 0; nxt = "R3";
      end else if (pnt) begin
        n_pc = id_taken ? id_target : m_pc + 4; n_idv = !id_taken; nxt = "R4";
      end else begin
        n_pc = id_taken ? id_target : m_pc + 4; n_idv = 1; nxt = "R5";
      end
      @(posedge clk);
      m_exv = m_idv && !m_ann;
      m_slot = dly && br;
      m_ann = dly && br && miss;
      m_pc = n_pc; m_idv = n_idv; pc_tag = nxt;
      @(negedge clk);
    end
  endtask

  initial begin
    do_reset(2'd0); run(400, 0);
    do_reset(2'd1); run(400, 0);
    do_reset(2'd3); run(200, 0);
    do_reset(2'd2); run(600, 0);
    do_reset(2'd2); run(150, 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule